// File: doc/BRIEF.md
# Bank Precharge and Read-Window Timing Tracker

This block follows the timing of one SDRAM bank inside a double-data-rate memory controller. The controller gives it one command per clock: activate, read (with or without auto-precharge), precharge, or no command. The block reports whether a precharge would be legal in the current cycle and whether a new activate would be legal. It also flags a precharge that cuts a read burst short, and any command that breaks the bank's timing.

It also models when read data is on the bus. Data starts CAS-latency cycles after a read and lasts for half the burst length in clocks, because two beats are transferred per clock. The output-drive window opens one cycle early and closes after the last beat. When a precharge arrives before the latest non-truncating edge, the last beat lands CAS-latency cycles after that precharge and the drivers switch off after it. The minimum row-open time and the precharge recovery time are given in picoseconds and converted at elaboration into whole clocks, rounding up.

Top module: `sdram_bank_timer`

## Requirements
- R1: Commands are coded on cmd_i as 0 none, 1 activate, 2 read, 3 precharge; auto_pre_i qualifies a read. Out of reset the bank is closed: ready_act_o=1, and ready_pre_o, data_valid_o, out_en_o, burst_cut_o and viol_o are all 0.
- R2: After an accepted activate at edge a, ready_pre_o rises in cycle a+ceil(tRAS/tCK)-1, so a precharge can first be sampled ceil(tRAS/tCK) edges after the activate. A precharge sampled earlier sets viol_o for one cycle and leaves the bank open.
- R3: After a precharge takes effect at edge p, ready_act_o rises in cycle p+ceil(tRP/tCK)-1. An activate sampled earlier sets viol_o for one cycle and is ignored.
- R4: A read accepted at edge r drives data_valid_o high for cycles r+CL through r+CL+BL/2-1.
- R5: out_en_o is high from one cycle before the first data cycle through the last data cycle and is low in the cycle after the last beat.
- R6: A precharge at edge p with p >= r+BL/2-1 leaves the burst intact. One at r < p < r+BL/2-1 truncates it: the last data cycle becomes p+CL, and burst_cut_o is high in cycle p only.
- R7: A read with auto-precharge at edge r closes the bank internally at edge r+BL/2-1. While that is pending, ready_pre_o is 0, and an explicit precharge or a read sets viol_o and is ignored. ready_act_o follows R3 from the internal edge.
- R8: If the auto-precharge edge would come before the activate-to-precharge minimum is met, the internal precharge waits until the first legal edge, and ready_act_o moves out by the same amount.
- R9: A read while the bank is not open sets viol_o and produces no data window.
- R10: A read accepted while an earlier burst is still being issued restarts the burst, so the data window runs BL/2 cycles past the later read with no gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 2 | Command for this bank (0 none, 1 activate, 2 read, 3 precharge) |
| auto_pre_i | input | 1 | Read carries auto-precharge |
| ready_pre_o | output | 1 | A precharge presented this cycle would be accepted |
| ready_act_o | output | 1 | An activate presented this cycle would be accepted |
| data_valid_o | output | 1 | Read data on the bus this cycle |
| out_en_o | output | 1 | Data drivers enabled (preamble through last beat) |
| burst_cut_o | output | 1 | One-cycle pulse: a precharge truncated a read burst |
| viol_o | output | 1 | One-cycle pulse: the previous command broke bank timing |

## Verification
The bench uses CAS latency 3, burst length 8, a 5000 ps clock, tRP of 18000 ps and tRAS of 42000 ps. Both analog limits fall between whole clocks, so the ceiling conversion is checked: 4 and 9 cycles rather than the truncated 3 and 8. Because tRAS is longer than a read plus its burst, a read with auto-precharge issued one cycle after activate reaches the delayed internal-precharge case. The short burst also gives an interrupting precharge room to land inside the burst, and lets a second read overlap the first.

// File: rtl/sdram_bank_pkg.sv
package sdram_bank_pkg;

  typedef enum logic [1:0] {
    CMD_NOP = 2'd0,
    CMD_ACT = 2'd1,
    CMD_RD  = 2'd2,
    CMD_PRE = 2'd3
  } bank_cmd_e;

  typedef enum logic [1:0] {
    BANK_IDLE    = 2'd0,
    BANK_OPEN    = 2'd1,
    BANK_CLOSING = 2'd2
  } bank_state_e;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

endpackage

// File: rtl/sdram_sat_ctr.sv
// Cycles-since counter: restart loads 1, then counts up and holds at LIMIT.
module sdram_sat_ctr #(
  parameter int W     = 4,
  parameter int LIMIT = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         restart_i,
  output logic [W-1:0] cnt_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_o <= '0;
    else if (restart_i)         cnt_o <= W'(1);
    else if (cnt_o < W'(LIMIT)) cnt_o <= cnt_o + W'(1);
  end

endmodule

// File: rtl/sdram_rd_window.sv
// Burst issue counter plus a CL-deep delay line that forms the data and drive windows.
module sdram_rd_window #(
  parameter int CL        = 3,
  parameter int BURST_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_start_i,
  input  logic pre_i,
  output logic cut_o,
  output logic data_valid_o,
  output logic out_en_o
);

  localparam int BW = $clog2(BURST_CYC + 1);

  logic [BW-1:0] left_q;
  logic          issue;
  logic [CL-1:0] dly_q;

  assign issue = (left_q != '0);
  // more than one issue cycle would remain after this edge
  assign cut_o = pre_i && (left_q > BW'(2));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           left_q <= '0;
    else if (rd_start_i)   left_q <= BW'(BURST_CYC);
    else if (cut_o)        left_q <= BW'(1);
    else if (issue)        left_q <= left_q - BW'(1);
  end

  generate
    if (CL == 1) begin : g_dly_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) dly_q <= '0;
        else         dly_q <= issue;
      end
      assign out_en_o = dly_q[0] | issue;
    end else begin : g_dly_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) dly_q <= '0;
        else         dly_q <= {dly_q[CL-2:0], issue};
      end
      assign out_en_o = dly_q[CL-1] | dly_q[CL-2];
    end
  endgenerate

  assign data_valid_o = dly_q[CL-1];

endmodule

// File: rtl/sdram_bank_timer.sv
module sdram_bank_timer #(
  parameter int CAS_LAT   = 3,
  parameter int BURST_LEN = 8,
  parameter int TCK_PS    = 5000,
  parameter int TRP_PS    = 18000,
  parameter int TRAS_PS   = 42000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] cmd_i,
  input  logic       auto_pre_i,
  output logic       ready_pre_o,
  output logic       ready_act_o,
  output logic       data_valid_o,
  output logic       out_en_o,
  output logic       burst_cut_o,
  output logic       viol_o
);
  import sdram_bank_pkg::*;

  localparam int BURST_CYC = BURST_LEN / 2;
  localparam int TRP_CYC   = ceil_div(TRP_PS, TCK_PS);
  localparam int TRAS_CYC  = ceil_div(TRAS_PS, TCK_PS);
  localparam int CMAX      = (TRAS_CYC > TRP_CYC) ? TRAS_CYC : TRP_CYC;
  localparam int CW        = $clog2(CMAX + 1);
  localparam int AW        = $clog2(BURST_CYC + 1);

  bank_cmd_e   cmd;
  bank_state_e state_q;
  logic        ap_pend_q;
  logic [AW-1:0] ap_cnt_q;
  logic [CW-1:0] ras_cnt, rp_cnt;
  logic        ras_met, rdy_pre, rdy_act;
  logic        act_ok, rd_ok, pre_ok, ap_fire, pre_fire, bad_cmd, cut;

  assign cmd = bank_cmd_e'(cmd_i);

  sdram_sat_ctr #(.W(CW), .LIMIT(TRAS_CYC)) u_ras_ctr (
    .clk_i(clk_i), .rst_ni(rst_ni), .restart_i(act_ok), .cnt_o(ras_cnt)
  );

  sdram_sat_ctr #(.W(CW), .LIMIT(TRP_CYC)) u_rp_ctr (
    .clk_i(clk_i), .rst_ni(rst_ni), .restart_i(pre_fire), .cnt_o(rp_cnt)
  );

  assign ras_met  = ras_cnt >= CW'(TRAS_CYC);
  assign rdy_pre  = (state_q == BANK_OPEN) && ras_met && !ap_pend_q;
  assign rdy_act  = (state_q == BANK_IDLE) ||
                    ((state_q == BANK_CLOSING) && (rp_cnt >= CW'(TRP_CYC)));

  assign act_ok   = (cmd == CMD_ACT) && rdy_act;
  assign rd_ok    = (cmd == CMD_RD) && (state_q == BANK_OPEN) && !ap_pend_q;
  assign pre_ok   = (cmd == CMD_PRE) && rdy_pre;
  // internal precharge waits for both the burst point and tRAS
  assign ap_fire  = ap_pend_q && (ap_cnt_q == '0) && ras_met;
  assign pre_fire = pre_ok || ap_fire;
  assign bad_cmd  = (cmd != CMD_NOP) && !(act_ok || rd_ok || pre_ok);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       state_q <= BANK_IDLE;
    else if (act_ok)   state_q <= BANK_OPEN;
    else if (pre_fire) state_q <= BANK_CLOSING;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ap_pend_q <= 1'b0;
      ap_cnt_q  <= '0;
    end else if (rd_ok && auto_pre_i) begin
      ap_pend_q <= 1'b1;
      ap_cnt_q  <= AW'(BURST_CYC - 2);
    end else if (ap_fire) begin
      ap_pend_q <= 1'b0;
    end else if (ap_cnt_q != '0) begin
      ap_cnt_q  <= ap_cnt_q - AW'(1);
    end
  end

  sdram_rd_window #(.CL(CAS_LAT), .BURST_CYC(BURST_CYC)) u_rd_win (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_start_i  (rd_ok),
    .pre_i       (pre_fire),
    .cut_o       (cut),
    .data_valid_o(data_valid_o),
    .out_en_o    (out_en_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      viol_o      <= 1'b0;
      burst_cut_o <= 1'b0;
    end else begin
      viol_o      <= bad_cmd;
      burst_cut_o <= cut;
    end
  end

  assign ready_pre_o = rdy_pre;
  assign ready_act_o = rdy_act;

endmodule

// File: rtl/sdram_bank_timer_chk.sv
module sdram_bank_timer_chk #(
  parameter int TCK_PS  = 5000,
  parameter int TRAS_PS = 42000
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] cmd_i,
  input logic       auto_pre_i,
  input logic       ready_pre_o,
  input logic       ready_act_o,
  input logic       data_valid_o,
  input logic       out_en_o,
  input logic       burst_cut_o,
  input logic       viol_o
);
  localparam int TRAS_CYC = (TRAS_PS + TCK_PS - 1) / TCK_PS;
  localparam int SW = $clog2(TRAS_CYC + 1);

  logic [SW-1:0] since_act;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            since_act <= '0;
    else if (cmd_i == 2'd1 && ready_act_o)  since_act <= '0;
    else if (since_act < SW'(TRAS_CYC))     since_act <= since_act + SW'(1);
  end

  p_pre_after_ras_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_pre_o |-> (since_act >= SW'(TRAS_CYC - 1)));

  p_early_pre_flag_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == 2'd3 && !ready_pre_o) |=> viol_o);

  p_early_act_flag_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == 2'd1 && !ready_act_o) |=> viol_o);

  p_act_closes_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == 2'd1 && ready_act_o) |=> (!ready_act_o && !viol_o));

  p_oe_covers_data_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_valid_o |-> out_en_o);

  p_oe_off_after_data_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(out_en_o) |-> $past(data_valid_o));

  p_cut_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_cut_o |=> !burst_cut_o);

  p_ap_blocks_pre_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == 2'd2 && auto_pre_i) |=> !ready_pre_o);

  p_ready_exclusive_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ready_pre_o && ready_act_o));

endmodule

bind sdram_bank_timer sdram_bank_timer_chk #(
  .TCK_PS (TCK_PS),
  .TRAS_PS(TRAS_PS)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_i       (cmd_i),
  .auto_pre_i  (auto_pre_i),
  .ready_pre_o (ready_pre_o),
  .ready_act_o (ready_act_o),
  .data_valid_o(data_valid_o),
  .out_en_o    (out_en_o),
  .burst_cut_o (burst_cut_o),
  .viol_o      (viol_o)
);

// File: tb/tb_sdram_bank_timer.sv
`timescale 1ns/1ps
module tb_sdram_bank_timer;
  localparam int S_RP = 0, S_RA = 1, S_DV = 2, S_OE = 3, S_CUT = 4, S_VIOL = 5;
  localparam logic [1:0] C_NOP = 2'd0, C_ACT = 2'd1, C_RD = 2'd2, C_PRE = 2'd3;

  typedef struct {
    int    cyc;
    int    sig;
    bit    val;
    string req;
  } exp_t;

  logic clk = 1'b0, rst_ni = 1'b0, auto_pre = 1'b0;
  logic [1:0] cmd = 2'd0;
  logic rdy_pre, rdy_act, dv, oe, cut, viol;
  int cyc = 0, checks = 0, errors = 0;
  bit done = 1'b0;
  exp_t q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sdram_bank_timer #(
    .CAS_LAT(3), .BURST_LEN(8), .TCK_PS(5000), .TRP_PS(18000), .TRAS_PS(42000)
  ) dut (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_i(cmd), .auto_pre_i(auto_pre),
    .ready_pre_o(rdy_pre), .ready_act_o(rdy_act), .data_valid_o(dv),
    .out_en_o(oe), .burst_cut_o(cut), .viol_o(viol)
  );

  function automatic bit sig_val(int s);
    case (s)
      S_RP:    return rdy_pre;
      S_RA:    return rdy_act;
      S_DV:    return dv;
      S_OE:    return oe;
      S_CUT:   return cut;
      default: return viol;
    endcase
  endfunction

  function automatic string sig_name(int s);
    case (s)
      S_RP:    return "ready_pre";
      S_RA:    return "ready_act";
      S_DV:    return "data_valid";
      S_OE:    return "out_en";
      S_CUT:   return "burst_cut";
      default: return "viol";
    endcase
  endfunction

  task automatic expect_at(int c, int s, bit v, string req);
    exp_t e;
    e.cyc = c; e.sig = s; e.val = v; e.req = req;
    q.push_back(e);
  endtask

  // monitor: compare every expectation due in this cycle
  always @(negedge clk) begin
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].cyc <= cyc) begin
        checks++;
        if (q[i].cyc < cyc || sig_val(q[i].sig) !== q[i].val) begin
          errors++;
          $display("FAIL %s cycle %0d %s actual=%0b expected=%0b", q[i].req,
                   q[i].cyc, sig_name(q[i].sig), sig_val(q[i].sig), q[i].val);
        end
        q.delete(i);
      end
    end
  end

  // caller sits at a negedge; command is sampled at edge e
  task automatic drive(int e, logic [1:0] c, logic ap);
    while (cyc < e - 1) @(negedge clk);
    if (cyc != e - 1) begin
      checks++; errors++;
      $display("FAIL sequencing edge %0d actual=%0d expected=%0d", e, cyc + 1, e);
    end
    cmd = c; auto_pre = ap;
    @(negedge clk);
    cmd = C_NOP; auto_pre = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int e0, a, r, p, a2, r2, p2, a3, r3, a4, r4, a5, r5;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1 reset state
    for (int s = 0; s < 6; s++) expect_at(cyc + 1, s, (s == S_RA), "R1");

    // R9 read on a closed bank
    e0 = cyc + 2;
    expect_at(e0, S_VIOL, 1, "R9");
    expect_at(e0 + 3, S_DV, 0, "R9");
    expect_at(e0 + 4, S_OE, 0, "R9");
    drive(e0, C_RD, 1'b0);

    // R2/R3/R4/R5/R6: activate, early precharge, read, boundary precharge
    a = e0 + 3;
    expect_at(a, S_RA, 0, "R3");
    expect_at(a + 4, S_VIOL, 0, "R2");
    expect_at(a + 5, S_VIOL, 1, "R2");
    expect_at(a + 7, S_RP, 0, "R2");
    expect_at(a + 8, S_RP, 1, "R2");
    drive(a, C_ACT, 1'b0);
    drive(a + 5, C_PRE, 1'b0);
    r = a + 10;
    expect_at(r + 1, S_OE, 0, "R5");
    expect_at(r + 2, S_OE, 1, "R5");
    expect_at(r + 2, S_DV, 0, "R4");
    expect_at(r + 3, S_DV, 1, "R4");
    expect_at(r + 6, S_DV, 1, "R4");
    expect_at(r + 6, S_OE, 1, "R5");
    expect_at(r + 7, S_DV, 0, "R4");
    expect_at(r + 7, S_OE, 0, "R5");
    drive(r, C_RD, 1'b0);
    p = r + 3;
    expect_at(p, S_CUT, 0, "R6");
    expect_at(p + 2, S_RA, 0, "R3");
    expect_at(p + 2, S_VIOL, 1, "R3");
    expect_at(p + 3, S_RA, 1, "R3");
    drive(p, C_PRE, 1'b0);
    drive(p + 2, C_ACT, 1'b0);

    // R6 interrupted burst, R9 read after close
    a2 = p + 4;
    expect_at(a2, S_VIOL, 0, "R3");
    drive(a2, C_ACT, 1'b0);
    r2 = a2 + 9;
    p2 = r2 + 1;
    expect_at(r2 + 3, S_DV, 1, "R6");
    expect_at(r2 + 4, S_DV, 1, "R6");
    expect_at(r2 + 5, S_DV, 0, "R6");
    expect_at(r2 + 5, S_OE, 0, "R6");
    expect_at(p2, S_CUT, 1, "R6");
    expect_at(p2 + 1, S_CUT, 0, "R6");
    expect_at(p2 + 1, S_VIOL, 1, "R9");
    expect_at(p2 + 6, S_DV, 0, "R9");
    drive(r2, C_RD, 1'b0);
    drive(p2, C_PRE, 1'b0);
    drive(p2 + 1, C_RD, 1'b0);

    // R7 read with auto-precharge, tRAS already met
    a3 = p2 + 4;
    drive(a3, C_ACT, 1'b0);
    r3 = a3 + 10;
    expect_at(r3 + 1, S_RP, 0, "R7");
    expect_at(r3 + 2, S_VIOL, 1, "R7");
    expect_at(r3 + 3, S_CUT, 0, "R7");
    expect_at(r3 + 3, S_DV, 1, "R7");
    expect_at(r3 + 6, S_DV, 1, "R7");
    expect_at(r3 + 7, S_DV, 0, "R7");
    expect_at(r3 + 5, S_RA, 0, "R7");
    expect_at(r3 + 6, S_RA, 1, "R7");
    drive(r3, C_RD, 1'b1);
    drive(r3 + 2, C_RD, 1'b0);

    // R8 auto-precharge held back by tRAS
    a4 = r3 + 7;
    r4 = a4 + 1;
    expect_at(r4 + 3, S_DV, 1, "R8");
    expect_at(r4 + 6, S_DV, 1, "R8");
    expect_at(a4 + 6, S_VIOL, 1, "R7");
    expect_at(a4 + 8, S_RP, 0, "R8");
    expect_at(a4 + 11, S_RA, 0, "R8");
    expect_at(a4 + 12, S_RA, 1, "R8");
    drive(a4, C_ACT, 1'b0);
    drive(r4, C_RD, 1'b1);
    drive(a4 + 6, C_PRE, 1'b0);

    // R10 read during a burst restarts it
    a5 = a4 + 13;
    r5 = a5 + 2;
    expect_at(r5 + 3, S_DV, 1, "R10");
    expect_at(r5 + 5, S_DV, 1, "R10");
    expect_at(r5 + 7, S_DV, 1, "R10");
    expect_at(r5 + 8, S_DV, 1, "R10");
    expect_at(r5 + 9, S_DV, 0, "R10");
    expect_at(r5 + 9, S_OE, 0, "R10");
    expect_at(r5 + 2, S_VIOL, 0, "R10");
    drive(a5, C_ACT, 1'b0);
    drive(r5, C_RD, 1'b0);
    drive(r5 + 2, C_RD, 1'b0);

    while (q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule